// File: doc/BRIEF.md
# Byte-Wide Host Bridge to a Word-Wide Core Port

This block lets an 8-bit processor reach a 16-bit register and RAM port. Two byte-wide staging registers sit between the host data bus and the core. A host write to one half of a word only fills its staging register. The write to the other half, the trigger byte, completes the word and starts a single 16-bit core write. A read of the trigger byte fetches the whole word from the core, returns its own half and keeps the other half staged. That half is then returned with no second core access.

Three static straps adapt the bridge to different 8-bit processor families. One strap picks the logic sense of the byte-address line and so the byte order. One picks which half acts as the trigger. The third picks between a host that waits on a ready handshake and a host that has no acknowledge input. Word addresses are 12 bits wide, which covers 4K words. All host inputs are sampled on the rising clock edge.

Top module: `byte_host_bridge`

## Requirements
- R1: During reset and right after it, `core_req` is 0 and `host_dout` is 0. `host_rdy` is 0 when `ack_mode`=1 and 1 when `ack_mode`=0.
- R2: The addressed half is the high byte when `host_a0` XOR `a0_sense` is 1, and the low byte otherwise. With `a0_sense`=0, `host_a0`=1 selects the high byte. With `a0_sense`=1, `host_a0`=0 selects the high byte.
- R3: A write to the non-trigger half stores the byte in its staging register and makes no core access.
- R4: A write to the trigger half makes exactly one core write (`core_we`=1) to `host_addr`. Its data is {high byte, low byte}, built from this byte and the staged other half.
- R5: A read of the trigger half makes exactly one core read and returns that half of `core_rdata` on `host_dout`.
- R6: A read of the non-trigger half returns the byte staged by the last trigger read and makes no core access.
- R7: With `trig_hi`=1 the high half is the trigger. With `trig_hi`=0 the low half is the trigger.
- R8: `core_req` stays high, with `core_addr`, `core_we` and `core_wdata` stable, until `core_ack` is sampled. It is low in the next cycle.
- R9: With `ack_mode`=1, `host_rdy` is 1 only after the access has completed, including its core transfer. It stays 1 until select or strobe is sampled low, and is 0 otherwise.
- R10: With `ack_mode`=0, `host_rdy` is 1 when idle. It is 0 from the cycle after a trigger access is sampled until its core transfer completes. The strobe may be released early and the access still completes.
- R11: One strobe assertion starts one access, however long it is held. A new access needs select and strobe to be sampled low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_mode | input | 1 | Strap: 1 = host waits on ready, 0 = host without acknowledge |
| a0_sense | input | 1 | Strap: sense of the byte-address line |
| trig_hi | input | 1 | Strap: 1 = high half triggers the word transfer |
| host_sel | input | 1 | Chip select, active high |
| host_stb | input | 1 | Access strobe, active high |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_a0 | input | 1 | Byte-address line |
| host_addr | input | 12 | Word address |
| host_din | input | 8 | Write byte |
| host_dout | output | 8 | Read byte |
| host_rdy | output | 1 | Ready to host |
| core_req | output | 1 | Word access request |
| core_we | output | 1 | 1 = word write |
| core_addr | output | 12 | Word address to core |
| core_wdata | output | 16 | Word write data |
| core_rdata | input | 16 | Word read data, valid with ack |
| core_ack | input | 1 | Core completion, one cycle |

## Verification
A non-trigger access sets ready one cycle after the strobe is sampled. A trigger access raises `core_req` in that same cycle. Ready then follows one cycle after the edge that samples `core_ack`. The bench core model answers after a fixed number of cycles, so ready on a trigger access is due that many cycles plus two after the strobe. The bench samples every output on the falling edge and counts falling edges from the strobe, so each latency check compares an exact count. The core model counts its acknowledges, which shows whether an access used the core or only the staging registers.

// File: rtl/byte_host_bridge_pkg.sv
package byte_host_bridge_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_XFER = 2'd1,
    BS_DONE = 2'd2
  } bridge_state_e;
endpackage

// File: rtl/bhb_lane_decode.sv
module bhb_lane_decode (
  input  logic a0_sense,
  input  logic trig_hi,
  input  logic host_a0,
  output logic lane_hi,
  output logic lane_trig
);
  always_comb begin
    lane_hi   = host_a0 ^ a0_sense;
    lane_trig = (lane_hi == trig_hi);
  end
endmodule

// File: rtl/bhb_stage.sv
module bhb_stage #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put_en,
  input  logic              put_hi,
  input  logic [BYTE_W-1:0] put_byte,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] staged
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_d;
    logic              lane_en;

    always_comb begin
      lane_en = load_en || (put_en && (put_hi == (g == 1)));
      lane_d  = load_en ? load_word[g*BYTE_W +: BYTE_W] : put_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= lane_d;
    end

    assign staged[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/bhb_ctrl.sv
module bhb_ctrl
  import byte_host_bridge_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_mode,
  input  logic              access,
  input  logic              rnw,
  input  logic              lane_hi,
  input  logic              lane_trig,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  input  logic [WORD_W-1:0] staged,
  input  logic              core_ack,
  input  logic [WORD_W-1:0] core_rdata,
  output logic              put_en,
  output logic              load_en,
  output logic              core_req,
  output logic              core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [WORD_W-1:0] core_wdata,
  output logic [BYTE_W-1:0] dout,
  output logic              rdy
);
  bridge_state_e     st_q, st_d;
  logic              we_q, hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic [BYTE_W-1:0] dout_q, dout_d;
  logic              start, cap_en, dout_en;

  always_comb begin
    st_d    = st_q;
    start   = 1'b0;
    dout_en = 1'b0;
    dout_d  = dout_q;
    load_en = 1'b0;
    unique case (st_q)
      BS_IDLE: begin
        if (access) begin
          start = 1'b1;
          st_d  = lane_trig ? BS_XFER : BS_DONE;
          if (rnw && !lane_trig) begin
            dout_en = 1'b1;
            dout_d  = lane_hi ? staged[WORD_W-1:BYTE_W] : staged[BYTE_W-1:0];
          end
        end
      end
      BS_XFER: begin
        if (core_ack) begin
          st_d = BS_DONE;
          if (!we_q) begin
            load_en = 1'b1;
            dout_en = 1'b1;
            dout_d  = hi_q ? core_rdata[WORD_W-1:BYTE_W] : core_rdata[BYTE_W-1:0];
          end
        end
      end
      BS_DONE: begin
        if (!access) st_d = BS_IDLE;
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_comb begin
    cap_en  = start && lane_trig;
    put_en  = start && !rnw;
    wdata_d = lane_hi ? {din, staged[BYTE_W-1:0]} : {staged[WORD_W-1:BYTE_W], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      hi_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      we_q    <= !rnw;
      hi_q    <= lane_hi;
      addr_q  <= addr;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= dout_d;
  end

  always_comb begin
    core_req   = (st_q == BS_XFER);
    core_we    = we_q;
    core_addr  = addr_q;
    core_wdata = wdata_q;
    dout       = dout_q;
    rdy        = ack_mode ? (st_q == BS_DONE) : (st_q != BS_XFER);
  end
endmodule

// File: rtl/byte_host_bridge.sv
module byte_host_bridge #(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_mode,
  input  logic              a0_sense,
  input  logic              trig_hi,
  input  logic              host_sel,
  input  logic              host_stb,
  input  logic              host_rnw,
  input  logic              host_a0,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_din,
  output logic [BYTE_W-1:0] host_dout,
  output logic              host_rdy,
  output logic              core_req,
  output logic              core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [WORD_W-1:0] core_wdata,
  input  logic [WORD_W-1:0] core_rdata,
  input  logic              core_ack
);
  logic              lane_hi, lane_trig, put_en, load_en, access;
  logic [WORD_W-1:0] staged;

  assign access = host_sel && host_stb;

  bhb_lane_decode u_dec (
    .a0_sense (a0_sense),
    .trig_hi  (trig_hi),
    .host_a0  (host_a0),
    .lane_hi  (lane_hi),
    .lane_trig(lane_trig)
  );

  bhb_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .put_en   (put_en),
    .put_hi   (lane_hi),
    .put_byte (host_din),
    .load_en  (load_en),
    .load_word(core_rdata),
    .staged   (staged)
  );

  bhb_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_mode  (ack_mode),
    .access    (access),
    .rnw       (host_rnw),
    .lane_hi   (lane_hi),
    .lane_trig (lane_trig),
    .addr      (host_addr),
    .din       (host_din),
    .staged    (staged),
    .core_ack  (core_ack),
    .core_rdata(core_rdata),
    .put_en    (put_en),
    .load_en   (load_en),
    .core_req  (core_req),
    .core_we   (core_we),
    .core_addr (core_addr),
    .core_wdata(core_wdata),
    .dout      (host_dout),
    .rdy       (host_rdy)
  );
endmodule

// File: rtl/byte_host_bridge_chk.sv
module byte_host_bridge_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_mode,
  input logic              host_sel,
  input logic              host_stb,
  input logic              host_rdy,
  input logic              core_req,
  input logic              core_we,
  input logic [ADDR_W-1:0] core_addr,
  input logic [WORD_W-1:0] core_wdata,
  input logic              core_ack
);
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_ack) |=> (core_req && $stable(core_addr) && $stable(core_we) && $stable(core_wdata)));

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_ack) |=> !core_req);

  assert_rdy_after_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mode && host_rdy) |-> !core_req);

  assert_busy_not_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> !host_rdy);

  assert_req_from_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_req) |-> $past(host_sel && host_stb));
endmodule

bind byte_host_bridge byte_host_bridge_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_mode  (ack_mode),
  .host_sel  (host_sel),
  .host_stb  (host_stb),
  .host_rdy  (host_rdy),
  .core_req  (core_req),
  .core_we   (core_we),
  .core_addr (core_addr),
  .core_wdata(core_wdata),
  .core_ack  (core_ack)
);

// File: tb/byte_host_bridge_test.sv
module byte_host_bridge_test;
  localparam int LAT = 2;

  logic        clk, rst_n;
  logic        ack_mode, a0_sense, trig_hi;
  logic        host_sel, host_stb, host_rnw, host_a0;
  logic [11:0] host_addr;
  logic [7:0]  host_din, host_dout;
  logic        host_rdy, core_req, core_we, core_ack;
  logic [11:0] core_addr;
  logic [15:0] core_wdata, core_rdata;

  int n_run, n_fail, acc_cnt, wait_cnt;
  logic [15:0] mem [0:4095];

  byte_host_bridge uut (
    .clk(clk), .rst_n(rst_n), .ack_mode(ack_mode), .a0_sense(a0_sense), .trig_hi(trig_hi),
    .host_sel(host_sel), .host_stb(host_stb), .host_rnw(host_rnw), .host_a0(host_a0),
    .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout), .host_rdy(host_rdy),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_ack(core_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // core model: acknowledges LAT cycles after it first sees a request
  initial begin
    core_ack = 1'b0; core_rdata = '0; wait_cnt = 0; acc_cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        core_ack = 1'b0; wait_cnt = 0;
      end else if (core_ack) begin
        core_ack = 1'b0;
      end else if (core_req) begin
        if (wait_cnt == LAT) begin
          core_ack = 1'b1; wait_cnt = 0; acc_cnt++;
          if (core_we) mem[core_addr] = core_wdata;
          else core_rdata = mem[core_addr];
        end else wait_cnt++;
      end
    end
  end

  task automatic xfer(input logic rd, input logic a0, input logic [11:0] addr,
                      input logic [7:0] wb, output logic [7:0] rb, output int cyc);
    @(negedge clk);
    host_sel = 1'b1; host_stb = 1'b1; host_rnw = rd; host_a0 = a0;
    host_addr = addr; host_din = wb;
    cyc = 0;
    if (ack_mode) begin
      do begin @(negedge clk); cyc++; end while (!host_rdy && cyc < 200);
      rb = host_dout;
      host_stb = 1'b0; host_sel = 1'b0;
    end else begin
      @(negedge clk); cyc = 1;
      host_stb = 1'b0; host_sel = 1'b0;
      while (!host_rdy && cyc < 200) begin @(negedge clk); cyc++; end
      rb = host_dout;
    end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic am; logic pol; logic thi; logic rd; logic a0;
    logic [11:0] addr; logic [7:0] wb; logic [7:0] eb;
    logic [1:0] acc; logic trig; logic [3:0] tag;
  } vec_t;

  localparam vec_t VEC [0:15] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'h005,8'hAB,8'h00,2'd0,1'b0,4'd3}, // R3 R2 stage high
    '{1'b1,1'b0,1'b0,1'b0,1'b0,12'h005,8'hCD,8'h00,2'd1,1'b1,4'd4}, // R4 low triggers
    '{1'b1,1'b0,1'b0,1'b1,1'b0,12'h005,8'h00,8'hCD,2'd1,1'b1,4'd5}, // R5
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'h005,8'h00,8'hAB,2'd0,1'b0,4'd6}, // R6
    '{1'b1,1'b1,1'b1,1'b0,1'b1,12'hFFF,8'h34,8'h00,2'd0,1'b0,4'd2}, // R2 inverted sense
    '{1'b1,1'b1,1'b1,1'b0,1'b0,12'hFFF,8'h12,8'h00,2'd1,1'b1,4'd7}, // R7 high triggers
    '{1'b1,1'b1,1'b1,1'b1,1'b0,12'hFFF,8'h00,8'h12,2'd1,1'b1,4'd5}, // R5
    '{1'b1,1'b1,1'b1,1'b1,1'b1,12'hFFF,8'h00,8'h34,2'd0,1'b0,4'd6}, // R6
    '{1'b1,1'b0,1'b0,1'b1,1'b0,12'hFFF,8'h00,8'h34,2'd1,1'b1,4'd2}, // R2 byte order swap
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'hFFF,8'h00,8'h12,2'd0,1'b0,4'd2}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,12'h100,8'h5A,8'h00,2'd0,1'b0,4'd10}, // R10 R3
    '{1'b0,1'b1,1'b0,1'b0,1'b1,12'h100,8'hA5,8'h00,2'd1,1'b1,4'd10}, // R10 R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,12'h100,8'h00,8'hA5,2'd1,1'b1,4'd10}, // R10 R5
    '{1'b0,1'b1,1'b0,1'b1,1'b0,12'h100,8'h00,8'h5A,2'd0,1'b0,4'd10}, // R10 R6
    '{1'b0,1'b0,1'b1,1'b1,1'b1,12'h100,8'h00,8'h5A,2'd1,1'b1,4'd7}, // R7
    '{1'b0,1'b0,1'b1,1'b1,1'b0,12'h100,8'h00,8'hA5,2'd0,1'b0,4'd7}  // R7
  };

  initial begin
    logic [7:0] rb;
    int cyc, base;
    n_run = 0; n_fail = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 3);
    rst_n = 1'b0; ack_mode = 1'b1; a0_sense = 1'b0; trig_hi = 1'b0;
    host_sel = 1'b0; host_stb = 1'b0; host_rnw = 1'b1; host_a0 = 1'b0;
    host_addr = '0; host_din = '0;
    repeat (3) @(negedge clk);
    check("R1 rdy handshake", host_rdy, 0);
    check("R1 core_req", core_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout", host_dout, 0);
    check("R1 core_req after release", core_req, 0);
    ack_mode = 1'b0; #1;
    check("R1 rdy no-ack host", host_rdy, 1);

    for (int v = 0; v < 16; v++) begin
      ack_mode = VEC[v].am; a0_sense = VEC[v].pol; trig_hi = VEC[v].thi;
      base = acc_cnt;
      xfer(VEC[v].rd, VEC[v].a0, VEC[v].addr, VEC[v].wb, rb, cyc);
      if (VEC[v].rd)
        check($sformatf("R%0d vec%0d data", VEC[v].tag, v), rb, VEC[v].eb);
      check($sformatf("R%0d vec%0d core accesses", VEC[v].tag, v), acc_cnt - base, VEC[v].acc);
      check($sformatf("R%0d vec%0d ready latency", VEC[v].tag, v), cyc,
            VEC[v].trig ? LAT + 2 : 1);
    end
    check("R4 word 005", mem[12'h005], 16'hABCD);
    check("R4 word FFF", mem[12'hFFF], 16'h1234);
    check("R4 word 100", mem[12'h100], 16'h5AA5);

    // R9, R11, R8: handshake trigger read with strobe held long
    ack_mode = 1'b1; a0_sense = 1'b0; trig_hi = 1'b0;
    base = acc_cnt;
    @(negedge clk);
    host_sel = 1'b1; host_stb = 1'b1; host_rnw = 1'b1; host_a0 = 1'b0; host_addr = 12'h005;
    @(negedge clk);
    check("R9 rdy low in transfer", host_rdy, 0);
    check("R8 req raised", core_req, 1);
    check("R8 addr presented", core_addr, 12'h005);
    host_addr = 12'h777;
    @(negedge clk);
    check("R8 addr stable", core_addr, 12'h005);
    repeat (LAT) @(negedge clk);
    check("R9 rdy after completion", host_rdy, 1);
    check("R8 req dropped", core_req, 0);
    repeat (5) @(negedge clk);
    check("R11 rdy held", host_rdy, 1);
    check("R11 single access", acc_cnt - base, 1);
    check("R5 held read data", host_dout, 8'hCD);
    host_stb = 1'b0; host_sel = 1'b0;
    @(negedge clk);
    check("R9 rdy drops on release", host_rdy, 0);

    // R10: no-ack host, strobe for one cycle on a trigger read
    ack_mode = 1'b0;
    @(negedge clk);
    check("R10 rdy idle", host_rdy, 1);
    host_sel = 1'b1; host_stb = 1'b1; host_a0 = 1'b1; host_addr = 12'hFFF;
    a0_sense = 1'b1; // a0=1 -> low byte, low triggers
    @(negedge clk);
    host_stb = 1'b0; host_sel = 1'b0;
    check("R10 rdy low while busy", host_rdy, 0);
    repeat (LAT + 1) @(negedge clk);
    check("R10 rdy back", host_rdy, 1);
    check("R10 early release data", host_dout, 8'h34);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule